// File: doc/BRIEF.md
# Interrupt and System Event Acceptance Tracker

This block holds the small set of flags that decide whether a processor core may accept an incoming INIT, SMI, NMI or maskable interrupt (INTR) in a given cycle. It is driven by one-cycle pulses. Some mark event arrivals. Some mark the retirement of the instructions that end a handler (interrupt return, return from system-management mode, halt). Others mark a triple fault and a floating-point wait that must freeze. From these pulses it keeps a block flag and a one-entry pending latch for each of INIT, SMI and NMI, plus four mode flags: in system-management mode, halted, shut down and FP-frozen.

In each cycle at most one event class is accepted. The block raises a one-cycle take strobe for that class, combinationally in the same cycle as the arrival or as the first cycle a latched event becomes eligible. The core's sequencer uses the strobe to start the matching entry flow. Every flag and latch changes on the following clock edge. Instruction decode, state saving and exception delivery belong to other blocks.

Top module: `evt_accept_tracker`

## Requirements
- R1: A cycle with `rst` high produces no take strobe, and after that edge every block flag, pending latch and mode flag reads 0.
- R2: After a cycle with `take_smi` high, `in_smm`, `blk_init`, `blk_smi` and `blk_nmi` all read 1, and `shutdown`, `halted` and `fp_frozen` read 0.
- R3: `blk_init` is set only by a taken SMI and is cleared by an `op_iret` or `op_rsm` pulse. If set and clear fall in the same cycle, the set wins.
- R4: `blk_smi` and `in_smm` are set by a taken SMI and cleared by `op_rsm` or by a taken INIT. If set and clear fall in the same cycle, the set wins.
- R5: `blk_nmi` is set by a taken SMI or a taken NMI and cleared by `op_iret` or by a taken INIT. If set and clear fall in the same cycle, the set wins.
- R6: An INIT, SMI or NMI arrival that is not taken in its cycle (blocked, or beaten by a higher class) sets that class's pending latch. Arrivals while the latch is full are dropped. A full latch makes its class eligible in every cycle its block is clear, and it empties on the edge after it is taken.
- R7: The take priority is INIT, then SMI, then NMI, then INTR. At most one take strobe is high in any cycle.
- R8: INTR is taken only when `ev_intr` and `intr_en` are high, `shutdown` is 0 and no higher class is taken. INTR is never latched.
- R9: `halted` is set by `op_hlt`, and also by `op_rsm` when `RSM_SETS_HALT` is 1. It is cleared by a take of any class, and the clear wins over a same-cycle set.
- R10: `shutdown` is set by `triple_fault` and cleared by a taken INIT, SMI or NMI (not INTR). The clear wins over a same-cycle set.
- R11: `fp_frozen` is set when `fp_wait`, `fp_unmasked_pend` are high and `cr0_ne`, `ignne` are low in the same cycle. It is cleared by a take of any class, and the clear wins.
- R12: No take strobe of INIT, SMI or NMI is raised while that class's block flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset pulse, active high |
| ev_init | input | 1 | INIT arrival pulse |
| ev_smi | input | 1 | SMI arrival pulse |
| ev_nmi | input | 1 | NMI arrival pulse |
| ev_intr | input | 1 | Maskable interrupt request |
| intr_en | input | 1 | Maskable interrupts enabled |
| op_iret | input | 1 | Interrupt-return retired |
| op_rsm | input | 1 | Return from system-management mode retired |
| op_hlt | input | 1 | Halt retired |
| triple_fault | input | 1 | Triple fault detected |
| fp_wait | input | 1 | Waiting FP operation executed |
| fp_unmasked_pend | input | 1 | Unmasked FP exception pending |
| cr0_ne | input | 1 | Native FP error reporting bit |
| ignne | input | 1 | Ignore-numeric-error input asserted |
| take_init | output | 1 | INIT accepted this cycle |
| take_smi | output | 1 | SMI accepted this cycle |
| take_nmi | output | 1 | NMI accepted this cycle |
| take_intr | output | 1 | INTR accepted this cycle |
| blk_init | output | 1 | INIT blocked |
| blk_smi | output | 1 | SMI blocked |
| blk_nmi | output | 1 | NMI blocked |
| pend_init | output | 1 | INIT latched |
| pend_smi | output | 1 | SMI latched |
| pend_nmi | output | 1 | NMI latched |
| in_smm | output | 1 | In system-management mode |
| halted | output | 1 | Halted |
| shutdown | output | 1 | Shut down |
| fp_frozen | output | 1 | FP freeze |

## Verification
The assertions assume that every input is a known 0 or 1 on each rising edge once reset has been applied, and that the reset pulse is sampled synchronously like any other input. They put no limit on how pulses combine. An arrival may coincide with a clearing instruction or with reset, and the set-versus-clear checks depend on those coincidences being legal. The stimulus changes inputs only on the falling edge and begins with reset held. It then covers every combination of the event and instruction pulses from the states the earlier steps leave behind, and it adds a long stretch of sparse random pulses with occasional resets.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int unsigned NCLS    = 4;
   localparam int unsigned NLATCH  = 3;
   localparam int unsigned IX_INIT = 0;
   localparam int unsigned IX_SMI  = 1;
   localparam int unsigned IX_NMI  = 2;
   localparam int unsigned IX_INTR = 3;
endpackage

// File: rtl/evt_prio_arb.sv
module evt_prio_arb #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   if (N < 1) begin : g_bad_n
      $fatal(1, "evt_prio_arb: N must be at least 1");
   end

   logic found;
   always_comb begin
      gnt   = '0;
      found = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/evt_hold_cell.sv
module evt_hold_cell (
   input  logic clk,
   input  logic rst,
   input  logic arrive,
   input  logic take,
   input  logic blk_set,
   input  logic blk_clr,
   output logic blk,
   output logic pend,
   output logic avail
);
   always_ff @(posedge clk) begin
      if (rst) begin
         blk  <= 1'b0;
         pend <= 1'b0;
      end else begin
         blk  <= blk_set | (blk & ~blk_clr);
         pend <= ~take & (pend | arrive);
      end
   end

   assign avail = (arrive | pend) & ~blk;

   AST_TAKE_UNBLOCKED: assert property (@(posedge clk) disable iff (rst) take |-> !blk); // R12
   AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst) (pend && !take) |=> pend); // R6
   AST_LATCH_DRAIN: assert property (@(posedge clk) disable iff (rst) take |=> !pend); // R6
   AST_BLOCK_SET_WINS: assert property (@(posedge clk) disable iff (rst) blk_set |=> blk); // R5
endmodule

// File: rtl/evt_mode_flag.sv
module evt_mode_flag #(
   parameter int unsigned CLEAR_WINS = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   if (CLEAR_WINS > 1) begin : g_bad_mode
      $fatal(1, "evt_mode_flag: CLEAR_WINS must be 0 or 1");
   end

   if (CLEAR_WINS == 1) begin : g_clr_wins
      always_ff @(posedge clk) begin
         if (rst) q <= 1'b0;
         else     q <= ~clr & (q | set);
      end
      AST_CLR_DOMINATES: assert property (@(posedge clk) disable iff (rst) clr |=> !q); // R9
   end else begin : g_set_wins
      always_ff @(posedge clk) begin
         if (rst) q <= 1'b0;
         else     q <= set | (q & ~clr);
      end
      AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (rst) set |=> q); // R4
   end
endmodule

// File: rtl/evt_accept_tracker.sv
module evt_accept_tracker #(
   parameter int unsigned RSM_SETS_HALT = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic ev_init,
   input  logic ev_smi,
   input  logic ev_nmi,
   input  logic ev_intr,
   input  logic intr_en,
   input  logic op_iret,
   input  logic op_rsm,
   input  logic op_hlt,
   input  logic triple_fault,
   input  logic fp_wait,
   input  logic fp_unmasked_pend,
   input  logic cr0_ne,
   input  logic ignne,
   output logic take_init,
   output logic take_smi,
   output logic take_nmi,
   output logic take_intr,
   output logic blk_init,
   output logic blk_smi,
   output logic blk_nmi,
   output logic pend_init,
   output logic pend_smi,
   output logic pend_nmi,
   output logic in_smm,
   output logic halted,
   output logic shutdown,
   output logic fp_frozen
);
   import evt_pkg::*;

   if (RSM_SETS_HALT > 1) begin : g_bad_rsm
      $fatal(1, "evt_accept_tracker: RSM_SETS_HALT must be 0 or 1");
   end

   logic [NLATCH-1:0] arr_v, blk_v, pend_v, avail_v, bset_v, bclr_v;
   logic [NCLS-1:0]   req_v, gnt_v;
   logic              halt_set, any_take, nmi_class_take, fp_set;

   assign arr_v[IX_INIT] = ev_init;
   assign arr_v[IX_SMI]  = ev_smi;
   assign arr_v[IX_NMI]  = ev_nmi;

   // block set/clear rules per latchable class
   assign bset_v[IX_INIT] = gnt_v[IX_SMI];
   assign bclr_v[IX_INIT] = op_iret | op_rsm;
   assign bset_v[IX_SMI]  = gnt_v[IX_SMI];
   assign bclr_v[IX_SMI]  = op_rsm | gnt_v[IX_INIT];
   assign bset_v[IX_NMI]  = gnt_v[IX_SMI] | gnt_v[IX_NMI];
   assign bclr_v[IX_NMI]  = op_iret | gnt_v[IX_INIT];

   for (genvar k = 0; k < int'(NLATCH); k++) begin : g_cell
      evt_hold_cell u_cell (
         .clk     (clk),
         .rst     (rst),
         .arrive  (arr_v[k]),
         .take    (gnt_v[k]),
         .blk_set (bset_v[k]),
         .blk_clr (bclr_v[k]),
         .blk     (blk_v[k]),
         .pend    (pend_v[k]),
         .avail   (avail_v[k])
      );
   end

   assign req_v[NLATCH-1:0] = avail_v & {NLATCH{~rst}};
   assign req_v[IX_INTR]    = ev_intr & intr_en & ~shutdown & ~rst;

   evt_prio_arb #(.N(NCLS)) u_arb (
      .req (req_v),
      .gnt (gnt_v)
   );

   assign any_take       = |gnt_v;
   assign nmi_class_take = |gnt_v[NLATCH-1:0];
   assign fp_set         = fp_wait & fp_unmasked_pend & ~cr0_ne & ~ignne;

   if (RSM_SETS_HALT == 1) begin : g_rsm_halt
      assign halt_set = op_hlt | op_rsm;
   end else begin : g_hlt_only
      assign halt_set = op_hlt;
   end

   evt_mode_flag #(.CLEAR_WINS(0)) u_smm (
      .clk (clk), .rst (rst),
      .set (gnt_v[IX_SMI]), .clr (op_rsm | gnt_v[IX_INIT]),
      .q   (in_smm)
   );
   evt_mode_flag #(.CLEAR_WINS(1)) u_halt (
      .clk (clk), .rst (rst), .set (halt_set), .clr (any_take), .q (halted)
   );
   evt_mode_flag #(.CLEAR_WINS(1)) u_shut (
      .clk (clk), .rst (rst), .set (triple_fault), .clr (nmi_class_take), .q (shutdown)
   );
   evt_mode_flag #(.CLEAR_WINS(1)) u_fpz (
      .clk (clk), .rst (rst), .set (fp_set), .clr (any_take), .q (fp_frozen)
   );

   assign take_init = gnt_v[IX_INIT];
   assign take_smi  = gnt_v[IX_SMI];
   assign take_nmi  = gnt_v[IX_NMI];
   assign take_intr = gnt_v[IX_INTR];
   assign blk_init  = blk_v[IX_INIT];
   assign blk_smi   = blk_v[IX_SMI];
   assign blk_nmi   = blk_v[IX_NMI];
   assign pend_init = pend_v[IX_INIT];
   assign pend_smi  = pend_v[IX_SMI];
   assign pend_nmi  = pend_v[IX_NMI];

   AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({take_init, take_smi, take_nmi, take_intr})); // R7
   AST_SMI_ENTRY: assert property (@(posedge clk) disable iff (rst)
      take_smi |=> (in_smm && blk_init && blk_smi && blk_nmi && !shutdown && !halted)); // R2
   AST_SHUT_NO_INTR: assert property (@(posedge clk) disable iff (rst) shutdown |-> !take_intr); // R8
   AST_INTR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) take_intr |-> intr_en); // R8
   AST_INIT_UNBLOCK: assert property (@(posedge clk) disable iff (rst)
      ((op_iret || op_rsm) && !take_smi) |=> !blk_init); // R3
   AST_SHUT_INTR_KEEP: assert property (@(posedge clk) disable iff (rst)
      (shutdown && !take_init && !take_smi && !take_nmi) |=> shutdown); // R10
endmodule

// File: tb/tb_evt_accept_tracker.sv
module tb_evt_accept_tracker;
   localparam int unsigned RSH = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ev_init = 0, ev_smi = 0, ev_nmi = 0, ev_intr = 0, intr_en = 0;
   logic op_iret = 0, op_rsm = 0, op_hlt = 0, triple_fault = 0;
   logic fp_wait = 0, fp_unmasked_pend = 0, cr0_ne = 0, ignne = 0;
   logic take_init, take_smi, take_nmi, take_intr;
   logic blk_init, blk_smi, blk_nmi, pend_init, pend_smi, pend_nmi;
   logic in_smm, halted, shutdown, fp_frozen;

   int n_chk = 0;
   int n_fail = 0;

   // reference state built from the requirements
   logic m_bi = 0, m_bs = 0, m_bn = 0, m_li = 0, m_ls = 0, m_ln = 0;
   logic m_smm = 0, m_h = 0, m_sd = 0, m_fp = 0;
   logic c_ti, c_ts, c_tn, c_tr;

   always #10 clk = ~clk;

   evt_accept_tracker #(.RSM_SETS_HALT(RSH)) dut (.*);

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      logic ti, ts, tn, tr, anyt, nclr;
      #5;
      if (rst) begin
         ti = 0; ts = 0; tn = 0; tr = 0;
      end else begin
         ti = (ev_init | m_li) & ~m_bi;
         ts = ~ti & (ev_smi | m_ls) & ~m_bs;
         tn = ~ti & ~ts & (ev_nmi | m_ln) & ~m_bn;
         tr = ~ti & ~ts & ~tn & ev_intr & intr_en & ~m_sd;
      end
      c_ti = take_init; c_ts = take_smi; c_tn = take_nmi; c_tr = take_intr;
      chk(rst ? "R1" : "R7", "take_init", take_init, ti);
      chk(rst ? "R1" : "R7", "take_smi", take_smi, ts);
      chk(rst ? "R1" : "R12", "take_nmi", take_nmi, tn);
      chk(rst ? "R1" : "R8", "take_intr", take_intr, tr);
      @(posedge clk);
      if (rst) begin
         {m_bi, m_bs, m_bn, m_li, m_ls, m_ln, m_smm, m_h, m_sd, m_fp} = '0;
      end else begin
         anyt  = ti | ts | tn | tr;
         nclr  = ti | ts | tn;
         m_bi  = ts | (m_bi & ~(op_iret | op_rsm));
         m_bs  = ts | (m_bs & ~(op_rsm | ti));
         m_bn  = ts | tn | (m_bn & ~(op_iret | ti));
         m_smm = ts | (m_smm & ~(op_rsm | ti));
         m_li  = ~ti & (m_li | ev_init);
         m_ls  = ~ts & (m_ls | ev_smi);
         m_ln  = ~tn & (m_ln | ev_nmi);
         m_h   = ~anyt & (m_h | op_hlt | ((RSH == 1) & op_rsm));
         m_sd  = ~nclr & (m_sd | triple_fault);
         m_fp  = ~anyt & (m_fp | (fp_wait & fp_unmasked_pend & ~cr0_ne & ~ignne));
      end
      @(negedge clk);
      chk("R3", "blk_init", blk_init, m_bi);
      chk("R4", "blk_smi", blk_smi, m_bs);
      chk("R5", "blk_nmi", blk_nmi, m_bn);
      chk("R6", "pend_init", pend_init, m_li);
      chk("R6", "pend_smi", pend_smi, m_ls);
      chk("R6", "pend_nmi", pend_nmi, m_ln);
      chk("R4", "in_smm", in_smm, m_smm);
      chk("R9", "halted", halted, m_h);
      chk("R10", "shutdown", shutdown, m_sd);
      chk("R11", "fp_frozen", fp_frozen, m_fp);
   endtask

   task automatic idle();
      rst = 0; ev_init = 0; ev_smi = 0; ev_nmi = 0; ev_intr = 0;
      op_iret = 0; op_rsm = 0; op_hlt = 0; triple_fault = 0;
      fp_wait = 0; fp_unmasked_pend = 0; cr0_ne = 0; ignne = 0;
   endtask

   task automatic do_reset();
      idle(); rst = 1; tick(); idle();
   endtask

   initial begin
      #(20 * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      rst = 1; tick(); tick(); idle();
      chk("R1", "blk_init", blk_init, 0); chk("R1", "pend_nmi", pend_nmi, 0);
      chk("R1", "in_smm", in_smm, 0); chk("R1", "halted", halted, 0);

      // R9 / R8: halt then wake by interrupt
      op_hlt = 1; tick(); idle();
      chk("R9", "halted after hlt", halted, 1);
      intr_en = 1; ev_intr = 1; tick(); idle();
      chk("R8", "intr taken", c_tr, 1);
      chk("R9", "halted cleared by intr", halted, 0);

      // R10 / R8: shutdown ignores interrupts
      triple_fault = 1; tick(); idle();
      chk("R10", "shutdown set", shutdown, 1);
      ev_intr = 1; tick(); idle();
      chk("R8", "intr refused in shutdown", c_tr, 0);
      chk("R10", "shutdown kept after intr", shutdown, 1);

      // R2: SMI entry
      ev_smi = 1; tick(); idle();
      chk("R2", "smi taken", c_ts, 1);
      chk("R2", "in_smm", in_smm, 1); chk("R2", "blk_init", blk_init, 1);
      chk("R2", "blk_nmi", blk_nmi, 1); chk("R2", "shutdown cleared", shutdown, 0);

      // R12 / R6: blocked NMI latches, second arrival dropped
      ev_nmi = 1; tick(); idle();
      chk("R12", "nmi not taken while blocked", c_tn, 0);
      chk("R6", "nmi latched", pend_nmi, 1);
      ev_nmi = 1; ev_smi = 1; tick(); idle();
      chk("R6", "nmi latch still one", pend_nmi, 1);
      chk("R6", "smi latched", pend_smi, 1);

      // R3 / R5: iret unblocks, latched NMI delivered next cycle
      op_iret = 1; tick(); idle();
      chk("R3", "blk_init cleared by iret", blk_init, 0);
      chk("R5", "blk_nmi cleared by iret", blk_nmi, 0);
      tick();
      chk("R6", "latched nmi delivered", c_tn, 1);
      chk("R6", "nmi latch emptied", pend_nmi, 0);
      chk("R5", "blk_nmi set by nmi", blk_nmi, 1);

      // R4 / R9: rsm leaves SMM, optional halt, latched SMI re-enters
      op_rsm = 1; tick(); idle();
      chk("R4", "in_smm cleared by rsm", in_smm, 0);
      chk("R4", "blk_smi cleared by rsm", blk_smi, 0);
      chk("R9", "halted set by rsm", halted, 1);
      tick();
      chk("R6", "latched smi delivered", c_ts, 1);
      chk("R9", "halted cleared by smi", halted, 0);

      // R3 / R4 / R5: latched INIT after rsm clears SMM state
      ev_init = 1; tick(); idle();
      chk("R6", "init latched", pend_init, 1);
      op_rsm = 1; tick(); idle();
      tick();
      chk("R7", "latched init delivered", c_ti, 1);
      chk("R5", "blk_nmi cleared by init", blk_nmi, 0);
      chk("R4", "in_smm after init", in_smm, 0);

      // R7: all classes at once from a clean state
      do_reset();
      intr_en = 1; ev_init = 1; ev_smi = 1; ev_nmi = 1; ev_intr = 1; tick(); idle();
      chk("R7", "init wins", c_ti, 1);
      chk("R7", "smi lost", c_ts, 0);
      chk("R6", "smi latched after losing", pend_smi, 1);
      chk("R6", "nmi latched after losing", pend_nmi, 1);

      // R11: fp freeze qualifiers
      do_reset();
      fp_wait = 1; fp_unmasked_pend = 1; cr0_ne = 1; tick(); idle();
      chk("R11", "no freeze with native errors", fp_frozen, 0);
      fp_wait = 1; fp_unmasked_pend = 1; ignne = 1; tick(); idle();
      chk("R11", "no freeze with ignne", fp_frozen, 0);
      fp_wait = 1; fp_unmasked_pend = 1; tick(); idle();
      chk("R11", "freeze set", fp_frozen, 1);
      ev_intr = 1; intr_en = 1; tick(); idle();
      chk("R11", "freeze cleared by intr", fp_frozen, 0);

      // R1: reset mid-run
      ev_smi = 1; op_hlt = 1; tick(); idle();
      ev_nmi = 1; tick(); idle();
      rst = 1; ev_init = 1; tick(); idle();
      chk("R1", "blk_smi after reset", blk_smi, 0);
      chk("R1", "pend_nmi after reset", pend_nmi, 0);
      chk("R1", "in_smm after reset", in_smm, 0);

      // sweep every pulse combination across the state left by earlier steps
      for (int rep = 0; rep < 3; rep++) begin
         for (int v = 0; v < 4096; v++) begin
            {ev_init, ev_smi, ev_nmi, ev_intr, intr_en, op_iret,
             op_rsm, op_hlt, triple_fault, fp_wait, fp_unmasked_pend, cr0_ne} = 12'(v ^ (rep * 1365));
            ignne = rep[0];
            rst = (v % 509) == 0;
            tick();
         end
      end

      // sparse random pulses
      idle();
      for (int n = 0; n < 20000; n++) begin
         rst          = ($urandom % 200) == 0;
         ev_init      = ($urandom % 11) == 0;
         ev_smi       = ($urandom % 9) == 0;
         ev_nmi       = ($urandom % 7) == 0;
         ev_intr      = ($urandom % 3) == 0;
         intr_en      = ($urandom % 2) == 0;
         op_iret      = ($urandom % 6) == 0;
         op_rsm       = ($urandom % 8) == 0;
         op_hlt       = ($urandom % 10) == 0;
         triple_fault = ($urandom % 25) == 0;
         fp_wait      = ($urandom % 5) == 0;
         fp_unmasked_pend = ($urandom % 2) == 0;
         cr0_ne       = ($urandom % 3) == 0;
         ignne        = ($urandom % 3) == 0;
         tick();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule